// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a chip's boundary-scan logic. It runs on the test clock. The mode-select input steers it through the sixteen-state controller, and an asynchronous active-low test reset puts it in a known state. A four-bit instruction register picks the data path that sits between the serial data input and the serial data output. The possible paths are a one-bit bypass stage, a 32-bit identification register, or an external boundary-scan chain. The external chain is reached through a return input and a set of capture, shift and update strobes.

The serial output changes only on the falling edge of the test clock. Its output enable is high only while a shift state is active. The strobes and the test-mode flag are plain level signals for the external chain. That chain takes its serial input directly from the data input pin. The block has no data stream with flow control, so no valid/ready handshake is used.

Top module: `tap_port`

## Requirements
- R1: The controller follows the standard sixteen-state transition graph on each rising test-clock edge, steered by the mode-select input. Holding mode-select high for five edges reaches Test-Logic-Reset from any state.
- R2: While `trst_n` is low, the controller is forced at once into Test-Logic-Reset. At the same time the active instruction becomes IDCODE (4'b0001), `tdo_oe` drops and `bsr_test_mode` is low.
- R3: Instruction decode works as follows. 4'b0000 selects the boundary chain with `bsr_test_mode`=1. 4'b0001 selects the identification register. 4'b0010 selects the boundary chain with `bsr_test_mode`=0. 4'b1111 selects bypass. Instruction bits are shifted in least significant bit first.
- R4: The codes 4'b0011 through 4'b1110 select the bypass stage, with `bsr_test_mode`=0.
- R5: In Capture-IR the instruction shifter loads 4'b0001. The first bit shifted out is therefore 1, followed by 0, 0, 0.
- R6: The active instruction changes only on the edge that leaves Update-IR, or in Test-Logic-Reset. Shifting or pausing in the IR column does not change it.
- R7: In Capture-DR with IDCODE active, the 32-bit identifier loads and is then shifted out least significant bit first. Its layout is: bits 31..28 version (default 4'h3), bits 27..12 part field 16'h2850, bits 11..1 maker field 11'h001, and bit 0 equal to 1. The default value is 32'h3285_0003.
- R8: The bypass stage captures 0 in Capture-DR. During Shift-DR it delays the data input by exactly one bit.
- R9: `tdo` and `tdo_oe` update only on the falling test-clock edge. `tdo_oe` is 1 only in Shift-IR or Shift-DR.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are high during Capture-DR, Shift-DR and Update-DR respectively, and only when a boundary instruction is active. In Shift-DR with a boundary instruction active, `bsr_tdo` is what appears on `tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data input |
| bsr_tdo | input | 1 | Serial return from the external boundary chain |
| tdo | output | 1 | Serial data output, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_capture | output | 1 | Boundary chain capture strobe |
| bsr_shift | output | 1 | Boundary chain shift strobe |
| bsr_update | output | 1 | Boundary chain update strobe |
| bsr_test_mode | output | 1 | Boundary cells drive pins (external test) |

## Verification
Every defined opcode and three reserved opcodes are loaded. An eight-bit data scan then follows each one, using an asymmetric serial pattern. This separates the three paths by their output: the identifier's fixed low bits, the one-bit delayed echo from bypass, and an inverted echo from a modelled boundary chain. The boundary strobe counts separate the two boundary opcodes from the rest. Directed scans cover the full 32-bit identifier and the captured instruction pattern. They also cover an instruction left in Pause-IR, a TMS-driven reset from inside Shift-DR, and an asynchronous reset in mid-scan. A probe between the rising and falling edges confirms that the output waits for the falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE_PAT = 4'b0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_t;

  typedef struct packed {
    logic sel_id;
    logic sel_bsr;
    logic sel_byp;
    logic test_mode;
  } tap_sel_t;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_t state
);
  tap_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= nxt;
  end

  AST_TLR_STICKY: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR)); // R1
  AST_SHIFT_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_SHF_DR && !tms) |=> (state == ST_SHF_DR)); // R1
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_t      state,
  input  logic            tdi,
  output logic            ir_tdo,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_sr <= IR_CAPTURE_PAT;
    else if (state == ST_CAP_IR) ir_sr <= IR_CAPTURE_PAT;
    else if (state == ST_SHF_IR) ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) ir_q <= OP_IDCODE;
    else if (state == ST_TLR) ir_q <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_q <= ir_sr;
  end

  assign ir_tdo = ir_sr[0];

  AST_IR_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_sr == 4'b0001)); // R5
  AST_IR_HOLD: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_TLR) |=> $stable(ir_q)); // R6
endmodule

// File: rtl/tap_decode.sv
module tap_decode
  import tap_pkg::*;
(
  input  logic [IR_W-1:0] ir_q,
  output tap_sel_t        sel
);
  always_comb begin
    sel = '0;
    unique case (ir_q)
      OP_EXTEST: begin sel.sel_bsr = 1'b1; sel.test_mode = 1'b1; end
      OP_SAMPLE: sel.sel_bsr = 1'b1;
      OP_IDCODE: sel.sel_id  = 1'b1;
      default:   sel.sel_byp = 1'b1;
    endcase
  end
endmodule

// File: rtl/tap_dr.sv
module tap_dr #(
  parameter int          ID_W = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h3285_0003
) (
  input  logic tck,
  input  logic trst_n,
  input  logic cap_dr,
  input  logic shf_dr,
  input  logic sel_id,
  input  logic sel_byp,
  input  logic tdi,
  output logic id_tdo,
  output logic byp_tdo
);
  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) id_sr <= ID_VALUE;
    else if (sel_id && cap_dr) id_sr <= ID_VALUE;
    else if (sel_id && shf_dr) id_sr <= {tdi, id_sr[ID_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) byp_q <= 1'b0;
    else if (sel_byp && cap_dr) byp_q <= 1'b0;
    else if (sel_byp && shf_dr) byp_q <= tdi;
  end

  assign id_tdo  = id_sr[0];
  assign byp_tdo = byp_q;

  AST_BYP_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_byp && cap_dr) |=> (byp_q == 1'b0)); // R8
  AST_ID_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
    (sel_id && cap_dr) |=> (id_sr == ID_VALUE)); // R7
endmodule

// File: rtl/tap_port.sv
module tap_port
  import tap_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int PART_W = 16,
  parameter int MFR_W  = 11,
  parameter logic [VER_W-1:0]  ID_VERSION = 4'h3,
  parameter logic [PART_W-1:0] ID_PART    = 16'h2850,
  parameter logic [MFR_W-1:0]  ID_MFR     = 11'h001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic bsr_test_mode
);
  localparam int ID_W = VER_W + PART_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

  tap_state_t      state;
  logic [IR_W-1:0] ir_q;
  logic            ir_tdo, id_tdo, byp_tdo;
  tap_sel_t        sel;
  logic            cap_dr, shf_dr, shf_ir, upd_dr;
  logic            dr_bit, tdo_nxt;

  tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

  tap_ir u_ir (.tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
               .ir_tdo(ir_tdo), .ir_q(ir_q));

  tap_decode u_dec (.ir_q(ir_q), .sel(sel));

  assign cap_dr = (state == ST_CAP_DR);
  assign shf_dr = (state == ST_SHF_DR);
  assign upd_dr = (state == ST_UPD_DR);
  assign shf_ir = (state == ST_SHF_IR);

  tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
    .tck(tck), .trst_n(trst_n), .cap_dr(cap_dr), .shf_dr(shf_dr),
    .sel_id(sel.sel_id), .sel_byp(sel.sel_byp), .tdi(tdi),
    .id_tdo(id_tdo), .byp_tdo(byp_tdo));

  assign bsr_capture   = cap_dr && sel.sel_bsr;
  assign bsr_shift     = shf_dr && sel.sel_bsr;
  assign bsr_update    = upd_dr && sel.sel_bsr;
  assign bsr_test_mode = sel.test_mode;

  always_comb begin
    if (sel.sel_id)       dr_bit = id_tdo;
    else if (sel.sel_bsr) dr_bit = bsr_tdo;
    else                  dr_bit = byp_tdo;
  end

  assign tdo_nxt = shf_ir ? ir_tdo : (shf_dr ? dr_bit : 1'b0);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_nxt;
      tdo_oe <= shf_ir || shf_dr;
    end
  end

  AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR)); // R9
  AST_ONE_PATH: assert property (@(posedge tck) disable iff (!trst_n)
    $countones({sel.sel_id, sel.sel_bsr, sel.sel_byp}) == 1); // R3
  AST_STROBE_EXCL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0({bsr_capture, bsr_shift, bsr_update})); // R10
  AST_TM_NEEDS_BSR: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_test_mode |-> sel.sel_bsr); // R4
endmodule

// File: tb/sim_tap_port.sv
`timescale 1ns/1ps
module sim_tap_port;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsr_tdo;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, bsr_test_mode;

  localparam logic [31:0] ID_EXP = 32'h3285_0003;
  localparam logic [7:0]  PAT    = 8'b1011_0010;
  localparam int K_ID = 0, K_BYP = 1, K_BSR = 2;
  localparam int NV = 8;
  // {opcode[6:3], test_mode[2], kind[1:0]}
  localparam logic [6:0] VEC [NV] = '{
    {4'b0000, 1'b1, 2'd2}, {4'b0001, 1'b0, 2'd0}, {4'b0010, 1'b0, 2'd2},
    {4'b1111, 1'b0, 2'd1}, {4'b0011, 1'b0, 2'd1}, {4'b0111, 1'b0, 2'd1},
    {4'b1110, 1'b0, 2'd1}, {4'b0001, 1'b0, 2'd0}};

  int n_chk = 0, n_bad = 0, n_cap = 0, n_shf = 0, n_upd = 0;
  bit done = 0;

  always #2.5 tck = ~tck;
  assign bsr_tdo = ~tdi;  // modelled external chain return

  tap_port u0 (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .bsr_test_mode(bsr_test_mode));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d);
    tms = t; tdi = d;
    #0.5;
    if (bsr_capture) n_cap++;
    if (bsr_shift)   n_shf++;
    if (bsr_update)  n_upd++;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin cap[i] = tdo; tick(i == 3, op[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0; n_cap = 0; n_shf = 0; n_upd = 0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin dout[i] = tdo; tick(i == n - 1, din[i]); end
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0] cap;
    logic [31:0] got, exp;
    @(negedge tck); #1;
    chk("R2 oe in reset", tdo_oe, 0);
    chk("R2 test_mode in reset", bsr_test_mode, 0);
    trst_n = 1'b1;
    tick(0, 0);  // to Run-Test/Idle
    chk("R9 oe low in idle", tdo_oe, 0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      load_ir(VEC[v][6:3], cap);
      chk("R5 capture-IR pattern", cap, 4'b0001);
      chk(VEC[v][1:0] == K_BYP && VEC[v][6:3] != 4'b1111 ? "R4 test_mode" : "R3 test_mode",
          bsr_test_mode, VEC[v][2]);
      scan_dr(8, PAT, got);
      exp = '0;
      for (int i = 0; i < 8; i++) begin
        if (VEC[v][1:0] == K_ID) exp[i] = ID_EXP[i];
        else if (VEC[v][1:0] == K_BYP) exp[i] = (i == 0) ? 1'b0 : PAT[i-1];
        else exp[i] = (i == 0) ? 1'b1 : ~PAT[i-1];
      end
      if (VEC[v][1:0] == K_ID) chk("R7 id low bits", got, exp);
      else if (VEC[v][1:0] == K_BYP) chk("R4 R8 bypass echo", got, exp);
      else chk("R10 bsr path", got, exp);
      chk("R10 strobe counts", {n_cap[7:0], n_shf[7:0], n_upd[7:0]},
          (VEC[v][1:0] == K_BSR) ? {8'd1, 8'd8, 8'd1} : 24'd0);
    end

    // full identifier
    load_ir(4'b0001, cap);
    scan_dr(32, 32'h0, got);
    chk("R7 full id", got, ID_EXP);

    // R6: instruction parked in Pause-IR does not take effect
    load_ir(4'b0000, cap);
    chk("R3 extest mode", bsr_test_mode, 1);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) tick(i == 3, i == 0);  // shift 0001
    tick(0, 0); tick(0, 0);  // Pause-IR
    chk("R6 held in pause", bsr_test_mode, 1);
    tick(1, 0); tick(1, 0);  // Exit2, Update-IR
    chk("R6 held in update", bsr_test_mode, 1);
    tick(0, 0);
    chk("R6 applied after update", bsr_test_mode, 0);

    // R1: TMS-driven reset from Shift-DR
    load_ir(4'b0000, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R9 oe in shift", tdo_oe, 1);
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    chk("R1 tms reset idcode", bsr_test_mode, 0);
    scan_dr(32, 32'h0, got);
    chk("R1 id after tms reset", got, ID_EXP);

    // R9: output waits for falling edge
    load_ir(4'b1111, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R8 bypass captured zero", tdo, 0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R9 tdo stable after rise", tdo, 0);
    @(negedge tck); #1;
    chk("R9 tdo after fall", tdo, 1);

    // R2: asynchronous reset mid-scan
    load_ir(4'b0000, cap);
    tick(1, 0); tick(0, 0); tick(0, 0);
    trst_n = 1'b0; #1;
    chk("R2 async oe", tdo_oe, 0);
    chk("R2 async mode", bsr_test_mode, 0);
    @(negedge tck); #1;
    trst_n = 1'b1;
    tick(0, 0);
    scan_dr(32, 32'h0, got);
    chk("R2 id after trst", got, ID_EXP);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule